// File: doc/BRIEF.md
# Fixed-Priority Shared Bus Controller

This block arbitrates a small shared bus among up to eight attached nodes. Each node has its own request line. The controller answers with a one-hot grant, an encoded grant index and a grant-valid flag. The grant is non-preemptive. It can change only while the bus is free. Node 0 has the highest priority and node 7 the lowest.

While a node holds the grant, it can raise its send strobe. On the next rising edge of the bus clock, the controller launches that node's 3-bit target address and data word onto the bus. On the falling edge that follows, the bus contents are captured into a holding register. On the next rising edge, the captured word is pushed into the receive queue of the addressed node. Each node has a 4-entry first-in first-out queue that it drains with its own pop strobe. A single-driver multiplexer models the tri-state data bus. When nothing drives the bus, it shows a fixed idle value, which defaults to all ones as a pull-up would.

The arbiter is a state machine with three states:
- ARB_IDLE: the bus is free and arbitration happens here. It moves to ARB_OWNED on any request, and the lowest-numbered requester becomes the owner. It stays in ARB_IDLE when there is no request.
- ARB_OWNED: one node holds the bus. It stays here while the owner keeps its request high. It moves to ARB_RELEASE when the owner's request is seen low.
- ARB_RELEASE: a one-cycle turnaround with no grant. It always moves to ARB_IDLE.

Top module: `shbus_ctrl`

## Requirements
- R1: After reset, all of the following hold: `grant` is 0, `grant_vld` is 0, `grant_idx` is 0, `bus_drive` is 0, `bus_data` equals the idle value (all ones by default), every `rx_empty` bit is 1, and every `rx_full` and `rx_ovf` bit is 0.
- R2: A rising clock edge in ARB_IDLE with at least one request bit set grants the bus to the lowest-numbered requester. After that edge, `grant_vld` is 1, `grant_idx` holds the winner's number, and `grant` has only bit `grant_idx` set.
- R3: While no request is active and the bus is free, no grant is issued. `bus_drive` stays 0 and `bus_data` shows the idle value.
- R4: While the owner keeps its request high, the grant does not change, even if a higher-priority request arrives.
- R5: At the first rising edge where the owner's request is low, the grant drops. The grant stays low after the next edge as well (ARB_RELEASE, then ARB_IDLE). Arbitration happens on the edge after that.
- R6: At a rising edge where a node holds the grant and its `src_send` bit is 1, that node's address and data appear on `bus_addr` and `bus_data`, and `bus_drive` goes to 1. The send strobe, address and data of any node without the grant have no effect on the bus.
- R7: A launched word is captured on the falling edge and pushed on the following rising edge into the queue of the node named by its 3-bit target address. Queue entries are read out in arrival order. `rx_data` shows the head entry while `rx_empty` is 0, and each `rx_pop` pulse removes one entry.
- R8: Each queue holds 4 entries, and `rx_full` is 1 when it holds 4. A word that arrives at a full queue is dropped, even if a pop happens in the same cycle, and it sets that queue's `rx_ovf`. `rx_ovf` stays set until reset.
- R9: At most one `grant` bit is set at any time. `grant_idx` is valid only while `grant_vld` is 1 and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock: launch on the rising edge, capture on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 8 | Request line per node; bit 0 has the highest priority |
| src_send | input | 8 | Per-node strobe to launch one word while granted |
| src_addr | input | 24 | Per-node 3-bit target address; node n uses bits [3n+2:3n] |
| src_data | input | 64 | Per-node 8-bit data word; node n uses bits [8n+7:8n] |
| rx_pop | input | 8 | Per-node strobe that removes the head of its receive queue |
| grant | output | 8 | One-hot grant (permission) per node |
| grant_vld | output | 1 | A grant is active |
| grant_idx | output | 3 | Encoded number of the granted node |
| bus_drive | output | 1 | The shared bus is being driven this cycle |
| bus_addr | output | 3 | Target address on the bus; 0 when undriven |
| bus_data | output | 8 | Shared data bus; idle value when undriven |
| rx_data | output | 64 | Head entry of each node's receive queue; node n uses bits [8n+7:8n] |
| rx_empty | output | 8 | Per-node receive queue is empty |
| rx_full | output | 8 | Per-node receive queue holds 4 entries |
| rx_ovf | output | 8 | Per-node sticky overflow flag |

## Verification
The bench raises a higher-priority request while another node holds the bus. A preemptive arbiter would move the grant at once, and the bench would see the index change. It checks the two-edge turnaround after release. A design that re-arbitrated in the same cycle, or skipped the dead cycle, would show a grant one edge too early. Another node asserts its send strobe at the same time as the owner. A multiplexer that picked the wrong node would put that node's word on the bus or in a queue. The bench also launches five words at one queue. A queue that overwrote its oldest entry, accepted a fifth word, or cleared the overflow flag while draining would return the wrong sequence or flag state.

// File: rtl/shbus_pkg.sv
package shbus_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE    = 2'd0,
        ARB_OWNED   = 2'd1,
        ARB_RELEASE = 2'd2
    } arb_state_e;

endpackage

// File: rtl/shbus_prio_pick.sv
module shbus_prio_pick #(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the lowest priority upwards so the lowest index is the last write.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/shbus_arb_fsm.sv
module shbus_arb_fsm
    import shbus_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic             grant_vld,
    output logic [IDX_W-1:0] grant_idx
);

    arb_state_e       st_q, st_d;
    logic [IDX_W-1:0] own_q;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;

    shbus_prio_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
        .req   (req),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // State register and owner capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ARB_IDLE;
            own_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ARB_IDLE && pick_found) begin
                own_q <= pick_idx;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ARB_IDLE:    if (pick_found)  st_d = ARB_OWNED;
            ARB_OWNED:   if (!req[own_q]) st_d = ARB_RELEASE;
            ARB_RELEASE: st_d = ARB_IDLE;
            default:     st_d = ARB_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        grant_vld = (st_q == ARB_OWNED);
        grant_idx = grant_vld ? own_q : '0;
        grant     = grant_vld ? (N'(1) << own_q) : '0;
    end

endmodule

// File: rtl/shbus_link.sv
module shbus_link #(
    parameter int          N        = 8,
    parameter int          IDX_W    = (N > 1) ? $clog2(N) : 1,
    parameter int          ADDR_W   = 3,
    parameter int          DATA_W   = 8,
    parameter logic [DATA_W-1:0] IDLE_VAL = '1
) (
    input  logic                outclk_unused_guard,
    input  logic                clk,
    input  logic                rst_n,
    input  logic                grant_vld,
    input  logic [IDX_W-1:0]    grant_idx,
    input  logic [N-1:0]        src_send,
    input  logic [N*ADDR_W-1:0] src_addr,
    input  logic [N*DATA_W-1:0] src_data,
    output logic                bus_drive,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_data,
    output logic                cap_vld,
    output logic [ADDR_W-1:0]   cap_addr,
    output logic [DATA_W-1:0]   cap_data
);

    logic              drv_q;
    logic [ADDR_W-1:0] drv_addr_q;
    logic [DATA_W-1:0] drv_data_q;
    logic              launch;

    // Only the granted node's strobe can launch a word.
    assign launch = grant_vld & src_send[grant_idx] & ~outclk_unused_guard;

    // Launch on the rising edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q      <= 1'b0;
            drv_addr_q <= '0;
            drv_data_q <= '0;
        end else begin
            drv_q <= launch;
            if (launch) begin
                drv_addr_q <= src_addr[grant_idx*ADDR_W +: ADDR_W];
                drv_data_q <= src_data[grant_idx*DATA_W +: DATA_W];
            end
        end
    end

    // Single-driver model of the shared bus.
    always_comb begin
        bus_drive = drv_q;
        bus_addr  = drv_q ? drv_addr_q : '0;
        bus_data  = drv_q ? drv_data_q : IDLE_VAL;
    end

    // Capture on the falling edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_vld  <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            cap_vld  <= bus_drive;
            cap_addr <= bus_addr;
            cap_data <= bus_data;
        end
    end

endmodule

// File: rtl/shbus_rxq.sv
module shbus_rxq #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full,
    output logic              ovf
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wp_q, rp_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              push, pop;

    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);
    assign push  = wr_en & ~full;
    assign pop   = rd_en & ~empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            ovf   <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (push) begin
                mem_q[wp_q] <= wr_data;
                wp_q        <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            end
            if (pop) begin
                rp_q <= (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            end
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
            if (wr_en && full)     ovf   <= 1'b1;
        end
    end

    assign rd_data = mem_q[rp_q];

endmodule

// File: rtl/shbus_ctrl.sv
module shbus_ctrl #(
    parameter int N       = 8,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 8,
    parameter int Q_DEPTH = 4,
    parameter logic [DATA_W-1:0] IDLE_VAL = '1,
    localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        req,
    input  logic [N-1:0]        src_send,
    input  logic [N*ADDR_W-1:0] src_addr,
    input  logic [N*DATA_W-1:0] src_data,
    input  logic [N-1:0]        rx_pop,
    output logic [N-1:0]        grant,
    output logic                grant_vld,
    output logic [IDX_W-1:0]    grant_idx,
    output logic                bus_drive,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_data,
    output logic [N*DATA_W-1:0] rx_data,
    output logic [N-1:0]        rx_empty,
    output logic [N-1:0]        rx_full,
    output logic [N-1:0]        rx_ovf
);

    logic              cap_vld;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;

    shbus_arb_fsm #(.N(N), .IDX_W(IDX_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .grant     (grant),
        .grant_vld (grant_vld),
        .grant_idx (grant_idx)
    );

    shbus_link #(
        .N(N), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDLE_VAL(IDLE_VAL)
    ) u_link (
        .outclk_unused_guard (1'b0),
        .clk       (clk),
        .rst_n     (rst_n),
        .grant_vld (grant_vld),
        .grant_idx (grant_idx),
        .src_send  (src_send),
        .src_addr  (src_addr),
        .src_data  (src_data),
        .bus_drive (bus_drive),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .cap_vld   (cap_vld),
        .cap_addr  (cap_addr),
        .cap_data  (cap_data)
    );

    // One receive queue per node, written when the captured address names it.
    for (genvar g = 0; g < N; g++) begin : g_rxq
        shbus_rxq #(.DEPTH(Q_DEPTH), .DATA_W(DATA_W)) u_q (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cap_vld && (cap_addr == ADDR_W'(g))),
            .wr_data (cap_data),
            .rd_en   (rx_pop[g]),
            .rd_data (rx_data[g*DATA_W +: DATA_W]),
            .empty   (rx_empty[g]),
            .full    (rx_full[g]),
            .ovf     (rx_ovf[g])
        );
    end

endmodule

// File: rtl/shbus_ctrl_chk.sv
module shbus_ctrl_chk #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     req,
    input logic [N-1:0]     grant,
    input logic             grant_vld,
    input logic [IDX_W-1:0] grant_idx,
    input logic             bus_drive,
    input logic [N-1:0]     rx_full,
    input logic [N-1:0]     rx_empty,
    input logic [N-1:0]     rx_ovf
);

    logic [N-1:0] req_q;
    logic [N-1:0] below_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req;
    end

    assign below_mask = (N'(1) << grant_idx) - N'(1);

    // R9
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R9
    grant_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> grant[grant_idx]);

    // R2
    winner_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_vld) |-> (req_q[grant_idx] && ((req_q & below_mask) == '0)));

    // R4
    hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && req[grant_idx]) |=> (grant_vld && $stable(grant_idx)));

    // R5
    release_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && !req[grant_idx]) |=> !grant_vld);

    // R5
    release_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant_vld) |=> !grant_vld);

    // R3
    no_grant_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_vld |=> !bus_drive);

    for (genvar g = 0; g < N; g++) begin : g_q_chk
        // R8
        ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rx_ovf[g] |=> rx_ovf[g]);

        // R8
        full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(rx_full[g] && rx_empty[g]));
    end

endmodule

bind shbus_ctrl shbus_ctrl_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .grant     (grant),
    .grant_vld (grant_vld),
    .grant_idx (grant_idx),
    .bus_drive (bus_drive),
    .rx_full   (rx_full),
    .rx_empty  (rx_empty),
    .rx_ovf    (rx_ovf)
);

// File: tb/shbus_ctrl_tb.sv
`timescale 1ns/1ps
module shbus_ctrl_tb;

    localparam int N = 8;
    localparam int AW = 3;
    localparam int DW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req = '0;
    logic [N-1:0]    src_send = '0;
    logic [N*AW-1:0] src_addr = '0;
    logic [N*DW-1:0] src_data = '0;
    logic [N-1:0]    rx_pop = '0;
    logic [N-1:0]    grant;
    logic            grant_vld;
    logic [2:0]      grant_idx;
    logic            bus_drive;
    logic [AW-1:0]   bus_addr;
    logic [DW-1:0]   bus_data;
    logic [N*DW-1:0] rx_data;
    logic [N-1:0]    rx_empty, rx_full, rx_ovf;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_q [N][$];
    int            model_cnt [N];

    shbus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .src_send(src_send),
        .src_addr(src_addr), .src_data(src_data), .rx_pop(rx_pop),
        .grant(grant), .grant_vld(grant_vld), .grant_idx(grant_idx),
        .bus_drive(bus_drive), .bus_addr(bus_addr), .bus_data(bus_data),
        .rx_data(rx_data), .rx_empty(rx_empty), .rx_full(rx_full), .rx_ovf(rx_ovf)
    );

    always #4 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic chk_grant(string tag, int idx);
        chk({tag, " grant_vld"}, 32'(grant_vld), 32'd1);
        chk({tag, " grant_idx"}, 32'(grant_idx), 32'(idx));
        chk({tag, " grant"}, 32'(grant), 32'(1 << idx));
    endtask

    task automatic chk_nogrant(string tag);
        chk({tag, " grant_vld"}, 32'(grant_vld), 32'd0);
        chk({tag, " grant"}, 32'(grant), 32'd0);
        chk({tag, " grant_idx"}, 32'(grant_idx), 32'd0);
    endtask

    // Driver: sets up one word for a node and records the expected queue effect.
    task automatic drive_word(int node, int tgt, logic [DW-1:0] d);
        src_addr[node*AW +: AW] = AW'(tgt);
        src_data[node*DW +: DW] = d;
        src_send[node] = 1'b1;
        if (model_cnt[tgt] < 4) begin
            exp_q[tgt].push_back(d);
            model_cnt[tgt]++;
        end
    endtask

    // Monitor: compares the queue head with the scoreboard and pops it.
    task automatic pop_check(int tgt);
        logic [DW-1:0] e;
        chk("R7 queue not empty", 32'(rx_empty[tgt]), 32'd0);
        e = exp_q[tgt].pop_front();
        model_cnt[tgt]--;
        chk("R7 fifo order data", 32'(rx_data[tgt*DW +: DW]), 32'(e));
        rx_pop[tgt] = 1'b1;
        tick();
        rx_pop[tgt] = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        summary();
    end

    initial begin
        for (int i = 0; i < N; i++) model_cnt[i] = 0;
        repeat (3) tick();
        // R1 reset state
        chk_nogrant("R1 reset");
        chk("R1 bus_drive", 32'(bus_drive), 32'd0);
        chk("R1 idle bus_data", 32'(bus_data), 32'hFF);
        chk("R1 rx_empty", 32'(rx_empty), 32'hFF);
        chk("R1 rx_full", 32'(rx_full), 32'h0);
        chk("R1 rx_ovf", 32'(rx_ovf), 32'h0);
        rst_n = 1'b1;
        tick();
        // R3 no request, no grant, bus idle
        chk_nogrant("R3 no request");
        chk("R3 idle bus_data", 32'(bus_data), 32'hFF);
        chk("R3 bus_drive", 32'(bus_drive), 32'd0);

        // R2 lowest requester among 3,5,7
        req = 8'b1010_1000;
        tick();
        chk_grant("R2 pick 3", 3);

        // R4 higher priority arrives while node 3 owns
        req = 8'b1010_1001;
        tick();
        chk_grant("R4 hold", 3);
        tick();
        chk_grant("R4 hold again", 3);

        // R6 owner launches; node 0 also strobes but lacks the grant
        drive_word(3, 5, 8'hA5);
        src_addr[0*AW +: AW] = 3'd5;
        src_data[0*DW +: DW] = 8'h11;
        src_send[0] = 1'b1;
        tick();
        src_send = '0;
        chk("R6 bus_drive", 32'(bus_drive), 32'd1);
        chk("R6 bus_addr", 32'(bus_addr), 32'd5);
        chk("R6 bus_data from owner only", 32'(bus_data), 32'hA5);
        tick();
        chk("R6 bus released after send", 32'(bus_drive), 32'd0);
        chk("R7 target 5 written", 32'(rx_empty[5]), 32'd0);
        chk("R7 other targets untouched", 32'(rx_empty & ~8'h20), 32'hDF);

        // R5 owner drops request
        req = 8'b1010_0001;
        tick();
        chk_nogrant("R5 drop edge");
        tick();
        chk_nogrant("R5 turnaround");
        tick();
        chk_grant("R5 R2 rearbitrate to 0", 0);

        // R8 five words into queue 2 from node 0
        for (int k = 0; k < 5; k++) begin
            drive_word(0, 2, DW'(8'h20 + k));
            tick();
        end
        src_send = '0;
        tick();
        chk("R8 rx_full at 4", 32'(rx_full[2]), 32'd1);
        chk("R8 rx_ovf on drop", 32'(rx_ovf[2]), 32'd1);
        chk("R8 no overflow elsewhere", 32'(rx_ovf & ~8'h04), 32'd0);

        // R7 drain in order (fifth word must be absent)
        for (int k = 0; k < 4; k++) pop_check(2);
        chk("R8 empty after four pops", 32'(rx_empty[2]), 32'd1);
        chk("R8 rx_ovf sticky", 32'(rx_ovf[2]), 32'd1);
        pop_check(5);
        chk("R6 ignored sender left no word", 32'(rx_empty[5]), 32'd1);

        // R3 everyone idle
        req = '0;
        repeat (3) tick();
        chk_nogrant("R3 R9 all idle");
        chk("R3 idle bus_data again", 32'(bus_data), 32'hFF);

        // R2 another pattern: nodes 6 and 7
        req = 8'b1100_0000;
        tick();
        chk_grant("R2 pick 6", 6);
        req = '0;
        repeat (2) tick();
        chk_nogrant("R9 after release");

        summary();
    end

endmodule